// File: doc/BRIEF.md
# Keyed Indexed Configuration Register Controller

This block is the configuration front end of a multi-function peripheral controller. It sits on a byte-wide host I/O bus and answers at two adjacent addresses. The lower address is the index port and the upper one is the data port. After reset the block is locked, in state `ST_RUN`. Writing the unlock key 0x55 to the index port moves it to `ST_CFG` (transition "unlock"). Writing the lock key 0xAA to the index port while unlocked moves it back to `ST_RUN` (transition "lock"). Every other index-port write leaves the state as it is. In `ST_RUN` any such write is ignored. In `ST_CFG` it is stored as the current register index.

While unlocked, the host writes a register index and then reads or writes the data port. A few registers are global: the bank select at 0x07, the chip identifier at 0x20 and the revision at 0x21. All other registers are banked. The bank select picks which logical device's set is visible. Each device has an enable bit, two 16-bit base addresses and two interrupt-select bytes, and these are presented as flat output vectors. Devices 1 and 2 are disk interfaces, 3 is the parallel port, 4 and 5 are serial ports, 7 is the keyboard and 8 is the global configuration bank. With the default of nine banks, devices 0 to 8 exist.

Read data is registered. It is valid in the cycle after the read strobe and holds until the next accepted read.

Top module: `keyed_cfg_ctrl`

## Requirements
- R1: After reset the block is locked, every device enable is 0, all base and interrupt outputs are 0, and `io_rdata` is 0x00.
- R2: While locked, writing 0x55 to the index port (0x3F0) unlocks the block. Any other index-port write while locked does not change the stored index (after unlock, a read of the index port returns the index held before).
- R3: While locked, reads of either port return 0xFF, and data-port (0x3F1) writes change no register and no output.
- R4: While unlocked, writing 0xAA to the index port locks the block again. Register contents are kept across lock and unlock.
- R5: Index 0x20 reads 0x30 and index 0x21 reads 0x01. Writes to both are ignored.
- R6: Index 0x07 is the bank select: a global 8-bit register, readable and writable whatever bank it holds.
- R7: Index 0x30 bit 0 enables the selected device and drives bit n of `dev_active` for device n. Bits 7:1 read back as 0.
- R8: Indices 0x60 (high byte) and 0x61 (low byte) form base address 0; indices 0x62 and 0x63 form base address 1. Device n occupies bits [16n+15:16n] of `dev_base0` and `dev_base1`.
- R9: Index 0x70 is interrupt select 0 and index 0x72 is interrupt select 1, 8 bits each. Device n occupies bits [8n+7:8n] of `dev_irq0` and `dev_irq1`.
- R10: Banked writes reach only the selected device. Banked reads return the selected device's values.
- R11: With a bank select of NUM_DEV or above, banked writes are ignored and banked reads return 0x00.
- R12: While unlocked, a read of the index port returns the current index, and an index with no register reads 0x00. Read data appears in the cycle after the read strobe.
- R13: Bus cycles at addresses other than the two ports have no effect on state, registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| dev_active | output | NUM_DEV | Enable bit of each device |
| dev_base0 | output | 16*NUM_DEV | Base address 0 of each device |
| dev_base1 | output | 16*NUM_DEV | Base address 1 of each device |
| dev_irq0 | output | 8*NUM_DEV | Interrupt select 0 of each device |
| dev_irq1 | output | 8*NUM_DEV | Interrupt select 1 of each device |

## Verification
The hardest thing to show from the ports is that traffic has no effect. This covers data-port writes while locked, index-port writes other than the key, writes to an out-of-range bank and writes at foreign addresses. None of these is visible in the cycle it happens. The stimulus therefore first loads known values into one bank. It then issues the ignored traffic, unlocks again where needed, and reads back both the stored index and the banked values while also watching the output vectors. Bank isolation is shown by programming two serial banks with different values and switching the select back and forth between reads.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
    typedef enum logic {
        ST_RUN = 1'b0,
        ST_CFG = 1'b1
    } cfg_state_e;

    localparam logic [7:0] KEY_UNLOCK = 8'h55;
    localparam logic [7:0] KEY_LOCK   = 8'hAA;

    localparam logic [7:0] IX_BANK    = 8'h07;
    localparam logic [7:0] IX_CHIP    = 8'h20;
    localparam logic [7:0] IX_REV     = 8'h21;
    localparam logic [7:0] IX_ENABLE  = 8'h30;
    localparam logic [7:0] IX_B0_HI   = 8'h60;
    localparam logic [7:0] IX_B0_LO   = 8'h61;
    localparam logic [7:0] IX_B1_HI   = 8'h62;
    localparam logic [7:0] IX_B1_LO   = 8'h63;
    localparam logic [7:0] IX_INT0    = 8'h70;
    localparam logic [7:0] IX_INT1    = 8'h72;

    localparam logic [7:0] CHIP_CODE  = 8'h30;
    localparam logic [7:0] CHIP_REV   = 8'h01;
endpackage

// File: rtl/kcr_key_fsm.sv
module kcr_key_fsm
    import kcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       in_cfg,
    output logic [7:0] cur_index
);
    cfg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next-state logic: unlock / lock transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (idx_wr && wdata == KEY_UNLOCK) state_d = ST_CFG;
            ST_CFG: if (idx_wr && wdata == KEY_LOCK)   state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        in_cfg = (state_q == ST_CFG);
    end

    // index is captured only while unlocked, and never from the lock key
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_index <= 8'h00;
        else if (idx_wr && state_q == ST_CFG && wdata != KEY_LOCK)
            cur_index <= wdata;
    end
endmodule

// File: rtl/kcr_bank.sv
module kcr_bank
    import kcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  index,
    input  logic [7:0]  wdata,
    output logic        active,
    output logic [15:0] base0,
    output logic [15:0] base1,
    output logic [7:0]  irq0,
    output logic [7:0]  irq1,
    output logic [7:0]  rd_byte
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base0  <= '0;
            base1  <= '0;
            irq0   <= '0;
            irq1   <= '0;
        end else if (wr_en) begin
            case (index)
                IX_ENABLE: active      <= wdata[0];
                IX_B0_HI:  base0[15:8] <= wdata;
                IX_B0_LO:  base0[7:0]  <= wdata;
                IX_B1_HI:  base1[15:8] <= wdata;
                IX_B1_LO:  base1[7:0]  <= wdata;
                IX_INT0:   irq0        <= wdata;
                IX_INT1:   irq1        <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (index)
            IX_ENABLE: rd_byte = {7'b0, active};
            IX_B0_HI:  rd_byte = base0[15:8];
            IX_B0_LO:  rd_byte = base0[7:0];
            IX_B1_HI:  rd_byte = base1[15:8];
            IX_B1_LO:  rd_byte = base1[7:0];
            IX_INT0:   rd_byte = irq0;
            IX_INT1:   rd_byte = irq1;
            default:   rd_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/keyed_cfg_ctrl.sv
module keyed_cfg_ctrl
    import kcr_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              NUM_DEV  = 9,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h03F0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic [NUM_DEV-1:0]    dev_active,
    output logic [16*NUM_DEV-1:0] dev_base0,
    output logic [16*NUM_DEV-1:0] dev_base1,
    output logic [8*NUM_DEV-1:0]  dev_irq0,
    output logic [8*NUM_DEV-1:0]  dev_irq1
);
    localparam logic [ADDR_W-1:0] DAT_ADDR = IDX_ADDR + 1'b1;

    logic       idx_hit, dat_hit;
    logic       in_cfg;
    logic [7:0] cur_index;
    logic [7:0] bank_sel;
    logic       data_wr;
    logic [7:0] bank_rd [NUM_DEV];
    logic [7:0] sel_rd;
    logic [7:0] rd_next;

    assign idx_hit = (io_addr == IDX_ADDR);
    assign dat_hit = (io_addr == DAT_ADDR);
    assign data_wr = io_wr && dat_hit && in_cfg;

    kcr_key_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (io_wr && idx_hit),
        .wdata     (io_wdata),
        .in_cfg    (in_cfg),
        .cur_index (cur_index)
    );

    // global bank select
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_sel <= 8'h00;
        else if (data_wr && cur_index == IX_BANK)
            bank_sel <= io_wdata;
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
        kcr_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (data_wr && bank_sel == 8'(g)),
            .index   (cur_index),
            .wdata   (io_wdata),
            .active  (dev_active[g]),
            .base0   (dev_base0[16*g +: 16]),
            .base1   (dev_base1[16*g +: 16]),
            .irq0    (dev_irq0[8*g +: 8]),
            .irq1    (dev_irq1[8*g +: 8]),
            .rd_byte (bank_rd[g])
        );
    end

    // selected bank readback; out-of-range select yields 0x00
    always_comb begin
        sel_rd = 8'h00;
        for (int k = 0; k < NUM_DEV; k++) begin
            if (bank_sel == 8'(k)) sel_rd = bank_rd[k];
        end
    end

    always_comb begin
        if (!in_cfg)
            rd_next = 8'hFF;
        else if (idx_hit)
            rd_next = cur_index;
        else begin
            case (cur_index)
                IX_BANK: rd_next = bank_sel;
                IX_CHIP: rd_next = CHIP_CODE;
                IX_REV:  rd_next = CHIP_REV;
                default: rd_next = sel_rd;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            io_rdata <= 8'h00;
        else if (io_rd && (idx_hit || dat_hit))
            io_rdata <= rd_next;
    end
endmodule

// File: rtl/keyed_cfg_ctrl_chk.sv
module keyed_cfg_ctrl_chk
    import kcr_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_DEV  = 9,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h03F0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     io_addr,
    input logic                  io_wr,
    input logic                  io_rd,
    input logic [7:0]            io_wdata,
    input logic [7:0]            io_rdata,
    input logic                  in_cfg,
    input logic [7:0]            cur_index,
    input logic [NUM_DEV-1:0]    dev_active,
    input logic [16*NUM_DEV-1:0] dev_base0,
    input logic [8*NUM_DEV-1:0]  dev_irq0
);
    localparam logic [ADDR_W-1:0] DAT_ADDR = IDX_ADDR + 1'b1;

    a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cfg && io_wr && io_addr == IDX_ADDR && io_wdata == KEY_UNLOCK) |=> in_cfg);

    a_r2_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cfg && !(io_wr && io_addr == IDX_ADDR && io_wdata == KEY_UNLOCK)) |=> !in_cfg);

    a_r4_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cfg && io_wr && io_addr == IDX_ADDR && io_wdata == KEY_LOCK) |=> !in_cfg);

    a_r3_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cfg && io_rd && io_addr == DAT_ADDR) |=> io_rdata == 8'hFF);

    a_r3_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !in_cfg |=> ($stable(dev_active) && $stable(dev_base0) && $stable(dev_irq0)));

    a_r5_chip_code: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cfg && io_rd && io_addr == DAT_ADDR && cur_index == IX_CHIP) |=> io_rdata == CHIP_CODE);

    a_r13_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != IDX_ADDR && io_addr != DAT_ADDR) |=> ($stable(cur_index) && $stable(dev_active)));
endmodule

bind keyed_cfg_ctrl keyed_cfg_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_DEV  (NUM_DEV),
    .IDX_ADDR (IDX_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .in_cfg     (in_cfg),
    .cur_index  (cur_index),
    .dev_active (dev_active),
    .dev_base0  (dev_base0),
    .dev_irq0   (dev_irq0)
);

// File: tb/test_keyed_cfg_ctrl.sv
`timescale 1ns/1ps
module test_keyed_cfg_ctrl;
    localparam int ND = 9;
    localparam logic [15:0] IXP = 16'h03F0;
    localparam logic [15:0] DTP = 16'h03F1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       io_addr = '0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        io_rdata;
    logic [ND-1:0]     dev_active;
    logic [16*ND-1:0]  dev_base0, dev_base1;
    logic [8*ND-1:0]   dev_irq0, dev_irq1;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    keyed_cfg_ctrl i_keyed_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active),
        .dev_base0(dev_base0), .dev_base1(dev_base1),
        .dev_irq0(dev_irq0), .dev_irq1(dev_irq1)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // driver: issue a read and push the expected byte onto the scoreboard
    task automatic bus_rd(logic [15:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        sb_q.push_back('{val: exp, req: req});
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(logic [7:0] ix, logic [7:0] d);
        bus_wr(IXP, ix);
        bus_wr(DTP, d);
    endtask

    task automatic reg_rd(logic [7:0] ix, logic [7:0] exp, string req);
        bus_wr(IXP, ix);
        bus_rd(DTP, exp, req);
    endtask

    // monitor: data is valid one edge after the strobe
    initial begin
        forever begin
            @(posedge clk);
            if (io_rd) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    chk("scoreboard_empty", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(e.req, {24'h0, io_rdata}, {24'h0, e.val});
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 active", {23'h0, dev_active}, 0);
        chk("R1 base0", dev_base0[31:0] | dev_base0[143:112], 0);
        chk("R1 irq", dev_irq0[31:0] | dev_irq1[71:40], 0);
        chk("R1 rdata", {24'h0, io_rdata}, 0);

        // R3 locked reads, R2 non-key index write, R3 ignored data write
        bus_rd(DTP, 8'hFF, "R3 locked data read");
        bus_rd(IXP, 8'hFF, "R3 locked index read");
        bus_wr(IXP, IX07());
        bus_wr(DTP, 8'h04);
        bus_wr(IXP, 8'h30);
        bus_wr(DTP, 8'h01);
        chk("R3 locked write active", {23'h0, dev_active}, 0);

        bus_wr(IXP, 8'h55);
        bus_rd(IXP, 8'h00, "R2 index untouched while locked");
        reg_rd(8'h07, 8'h00, "R3 bank select untouched");

        // R5
        reg_rd(8'h20, 8'h30, "R5 chip code");
        reg_rd(8'h21, 8'h01, "R5 revision");
        reg_wr(8'h20, 8'h99);
        reg_wr(8'h21, 8'h77);
        reg_rd(8'h20, 8'h30, "R5 chip code after write");
        reg_rd(8'h21, 8'h01, "R5 revision after write");

        // R6
        reg_wr(8'h07, 8'h04);
        reg_rd(8'h07, 8'h04, "R6 bank select");

        // R7
        reg_wr(8'h30, 8'hFF);
        reg_rd(8'h30, 8'h01, "R7 enable readback");
        chk("R7 dev_active", {23'h0, dev_active}, 32'h10);

        // R8
        reg_wr(8'h60, 8'h03);
        reg_wr(8'h61, 8'hF8);
        reg_wr(8'h62, 8'h12);
        reg_wr(8'h63, 8'h34);
        chk("R8 base0 dev4", {16'h0, dev_base0[64 +: 16]}, 32'h03F8);
        chk("R8 base1 dev4", {16'h0, dev_base1[64 +: 16]}, 32'h1234);
        reg_rd(8'h61, 8'hF8, "R8 base0 low readback");
        reg_rd(8'h62, 8'h12, "R8 base1 high readback");

        // R9
        reg_wr(8'h70, 8'h0A);
        reg_wr(8'h72, 8'h0C);
        chk("R9 irq0 dev4", {24'h0, dev_irq0[32 +: 8]}, 32'h0A);
        chk("R9 irq1 dev4", {24'h0, dev_irq1[32 +: 8]}, 32'h0C);
        reg_rd(8'h72, 8'h0C, "R9 irq1 readback");

        // R10 bank isolation
        reg_wr(8'h07, 8'h05);
        reg_wr(8'h60, 8'h02);
        reg_wr(8'h61, 8'hF8);
        reg_wr(8'h70, 8'h0B);
        chk("R10 dev5 base0", {16'h0, dev_base0[80 +: 16]}, 32'h02F8);
        chk("R10 dev4 base0 kept", {16'h0, dev_base0[64 +: 16]}, 32'h03F8);
        chk("R10 dev4 irq0 kept", {24'h0, dev_irq0[32 +: 8]}, 32'h0A);
        chk("R10 dev5 not enabled", {23'h0, dev_active}, 32'h10);
        reg_rd(8'h60, 8'h02, "R10 bank5 read");
        reg_wr(8'h07, 8'h04);
        reg_rd(8'h60, 8'h03, "R10 bank4 read");

        // R11 out-of-range bank
        reg_wr(8'h07, 8'h0F);
        reg_wr(8'h30, 8'h01);
        reg_wr(8'h61, 8'h55);
        chk("R11 no enable", {23'h0, dev_active}, 32'h10);
        reg_rd(8'h30, 8'h00, "R11 enable reads zero");
        reg_rd(8'h61, 8'h00, "R11 base reads zero");
        reg_wr(8'h07, 8'h04);
        reg_rd(8'h61, 8'hF8, "R11 dev4 untouched");

        // R12 index readback and unassigned index
        bus_wr(IXP, 8'h40);
        bus_rd(IXP, 8'h40, "R12 index readback");
        bus_rd(DTP, 8'h00, "R12 unassigned index");

        // R13 foreign addresses
        bus_wr(16'h03F2, 8'hAA);
        bus_wr(16'h02F0, 8'hAA);
        bus_wr(16'h02F1, 8'h00);
        bus_rd(IXP, 8'h40, "R13 still unlocked, index kept");
        chk("R13 outputs kept", {23'h0, dev_active}, 32'h10);

        // R4 lock, retention, re-unlock
        bus_wr(IXP, 8'hAA);
        bus_rd(DTP, 8'hFF, "R4 locked after key");
        bus_wr(DTP, 8'h00);
        chk("R4 locked write ignored", {23'h0, dev_active}, 32'h10);
        bus_wr(IXP, 8'h55);
        reg_rd(8'h07, 8'h04, "R4 bank select retained");
        reg_rd(8'h63, 8'h34, "R4 base retained");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    function automatic logic [7:0] IX07();
        return 8'h07;
    endfunction
endmodule